// File: doc/BRIEF.md
# Critical-Word-First Line Refill Unit

This unit services a load miss by fetching a whole cache line from the memory side. The line is 64 bytes and arrives as eight 64-bit beats. The unit does not ask for the line from its lowest chunk. It asks the memory side to begin at the chunk that holds the missing word and to wrap around the line from there. The requested chunk is therefore always the first beat to arrive, even when the miss falls in the middle of a line.

On the cycle that first beat arrives, the unit hands the chunk to the waiting load without delay. In that same cycle it also stores the chunk in its line buffer. The load can then resume while the other seven beats fill the buffer in the background. When the eighth beat has been captured, the unit writes the assembled line to the cache data array in a single write and raises a one-cycle completion pulse. A new miss is held off from the moment a fill is accepted until that pulse.

Tag lookup and victim selection belong to the surrounding cache and are not part of this unit.

Top module: `cwf_line_fill`

## Requirements
- R1: After reset, `miss_ready` is 1, and `ld_valid`, `line_done` and `mem_req_valid` are all 0.
- R2: In the cycle that a miss is accepted (`miss_valid` and `miss_ready` both high), `mem_req_valid` is 1. In that cycle, `mem_req_addr` equals `miss_addr` with its low 6 bits cleared, and `mem_req_start` equals `miss_addr[5:3]`.
- R3: On the first valid beat of a fill, `ld_valid` is 1 in that same cycle and `ld_data` equals `mem_beat_data`.
- R4: `ld_valid` stays 0 on the second through eighth beats of a fill, so the load is released exactly once per fill.
- R5: The beat numbered k (counting from 0) is placed in chunk (start+k) mod 8 of the line. Chunk i occupies bits [64*i+63 : 64*i] of `arr_wr_data`.
- R6: `line_done` is high for exactly one cycle, in the cycle after the eighth beat arrives. In that cycle `arr_wr_data` holds the full line, and `arr_wr_addr` holds the line-aligned miss address.
- R7: `miss_ready` is 0 from the cycle after a miss is accepted up to and including the `line_done` cycle. While it is 0, `miss_valid` raises no `mem_req_valid`. `miss_ready` returns to 1 in the cycle after `line_done`.
- R8: `mem_beat_valid` has no effect while no fill is in progress. It does not assert `ld_valid`, and it does not shift the placement of the beats of the next fill.
- R9: Cycles in which `mem_beat_valid` is 0 during a fill do not advance the beat order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A load miss is presented |
| miss_addr | input | ADDR_W | Byte address of the missing load |
| miss_ready | output | 1 | Unit can accept a miss this cycle |
| mem_req_valid | output | 1 | Line request to memory (one cycle) |
| mem_req_addr | output | ADDR_W | Line-aligned request address |
| mem_req_start | output | 3 | Chunk index at which the burst begins |
| mem_beat_valid | input | 1 | A refill beat is on `mem_beat_data` |
| mem_beat_data | input | CHUNK_W | Refill beat payload |
| ld_valid | output | 1 | Requested chunk delivered to the load |
| ld_data | output | CHUNK_W | Requested chunk |
| line_done | output | 1 | Full line written to the array (also the write strobe) |
| arr_wr_addr | output | ADDR_W | Line-aligned array write address |
| arr_wr_data | output | LINE_BYTES*8 | Assembled line, chunk i in bits [64*i+63 : 64*i] |

## Verification
The bench uses every start offset from 0 to 7. It checks that the first beat is the one delivered to the load. A unit that always requested chunk 0, or that delivered a later beat, would fail this check at most offsets. The bench then checks each chunk of the written line against its wrapped position. A unit with a wrap error, such as one that placed beat k at chunk k, would produce a scrambled line. The bench also inserts gaps between beats, to catch a counter that advances on idle cycles. It sends stray beats while idle, to catch a unit that starts a fill by itself. Finally, it holds a second miss during a fill, to catch a unit that re-issues a request or reopens too early.

// File: rtl/cwf_line_fill.sv
module cwf_line_fill #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int CHUNK_W    = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      miss_valid,
  input  logic [ADDR_W-1:0]         miss_addr,
  output logic                      miss_ready,
  output logic                      mem_req_valid,
  output logic [ADDR_W-1:0]         mem_req_addr,
  output logic [$clog2(LINE_BYTES*8/CHUNK_W)-1:0] mem_req_start,
  input  logic                      mem_beat_valid,
  input  logic [CHUNK_W-1:0]        mem_beat_data,
  output logic                      ld_valid,
  output logic [CHUNK_W-1:0]        ld_data,
  output logic                      line_done,
  output logic [ADDR_W-1:0]         arr_wr_addr,
  output logic [LINE_BYTES*8-1:0]   arr_wr_data
);

  localparam int NCHUNK = LINE_BYTES * 8 / CHUNK_W;
  localparam int IDX_W  = $clog2(NCHUNK);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int CB_W   = $clog2(CHUNK_W / 8);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_COMMIT} state_t;

  state_t            state_q;
  logic [IDX_W-1:0]  start_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] line_q;
  logic [CHUNK_W-1:0] buf_q [NCHUNK];

  logic             accept;
  logic             beat_in;
  logic             last_beat;
  logic [IDX_W-1:0] slot;

  assign miss_ready    = (state_q == S_IDLE);
  assign accept        = miss_valid && miss_ready;
  assign mem_req_valid = accept;
  assign mem_req_addr  = {miss_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_req_start = miss_addr[OFF_W-1:CB_W];

  assign beat_in   = (state_q == S_FILL) && mem_beat_valid;
  assign last_beat = beat_in && (cnt_q == IDX_W'(NCHUNK - 1));
  assign slot      = start_q + cnt_q;

  assign ld_valid  = beat_in && (cnt_q == '0);
  assign ld_data   = mem_beat_data;

  assign line_done   = (state_q == S_COMMIT);
  assign arr_wr_addr = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      start_q <= '0;
      cnt_q   <= '0;
      line_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          state_q <= S_FILL;
          start_q <= mem_req_start;
          cnt_q   <= '0;
          line_q  <= mem_req_addr;
        end
        S_FILL: if (beat_in) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_beat) state_q <= S_COMMIT;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
    always_ff @(posedge clk) begin
      if (!rst_n) buf_q[i] <= '0;
      else if (beat_in && slot == IDX_W'(i)) buf_q[i] <= mem_beat_data;
    end
    assign arr_wr_data[i*CHUNK_W +: CHUNK_W] = buf_q[i];
  end

  p_first_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (mem_beat_valid && ld_data == mem_beat_data));

  p_single_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ld_valid);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  p_busy_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !miss_ready);

  p_reopen_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> miss_ready);

  p_no_req_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_ready |-> !mem_req_valid);

  p_no_release_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> !ld_valid);

endmodule

// File: tb/cwf_line_fill_tb.sv
module cwf_line_fill_tb;
  localparam int ADDR_W = 32;
  localparam int LINE_W = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic [ADDR_W-1:0] miss_addr = '0;
  logic miss_ready, mem_req_valid;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [2:0] mem_req_start;
  logic mem_beat_valid = 1'b0;
  logic [63:0] mem_beat_data = '0;
  logic ld_valid, line_done;
  logic [63:0] ld_data;
  logic [ADDR_W-1:0] arr_wr_addr;
  logic [LINE_W-1:0] arr_wr_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cwf_line_fill u_dut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_start(mem_req_start),
    .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
    .ld_valid(ld_valid), .ld_data(ld_data),
    .line_done(line_done), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data)
  );

  localparam logic [31:0] V_ADDR [0:9] = '{
    32'h0000_1000, 32'h0000_2048, 32'h1234_5690, 32'h0000_03D8,
    32'hFFFF_FFE4, 32'h8000_0028, 32'h0ABC_DEF0, 32'h0000_0178,
    32'h0000_0020, 32'h7654_3218
  };
  localparam logic [31:0] V_SEED [0:9] = '{
    32'hDEAD_0001, 32'hBEEF_0002, 32'hCAFE_0003, 32'h1111_0004,
    32'h2222_0005, 32'h3333_0006, 32'h4444_0007, 32'h5555_0008,
    32'h6666_0009, 32'h7777_000A
  };
  localparam logic V_GAP [0:9] = '{0, 0, 1, 0, 1, 0, 0, 1, 0, 1};

  function automatic logic [63:0] chunk_val(input logic [31:0] seed, input int idx);
    return {seed, 8'hC0 + 8'(idx), 24'h5A_A55A};
  endfunction

  task automatic check(input bit ok, input string req, input logic [LINE_W-1:0] act,
                       input logic [LINE_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [31:0] addr, input logic [31:0] seed, input bit gap);
    int st;
    logic [LINE_W-1:0] exp_line;
    logic [31:0] exp_base;
    st = int'(addr[5:3]);
    exp_base = {addr[31:6], 6'b0};
    for (int i = 0; i < 8; i++) exp_line[i*64 +: 64] = chunk_val(seed, i);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = addr;
    #1;
    check(miss_ready && mem_req_valid, "R2 req_valid", {511'b0, mem_req_valid}, 1);
    check(mem_req_addr == exp_base, "R2 req_addr", mem_req_addr, exp_base);
    check(mem_req_start == 3'(st), "R2 req_start", mem_req_start, st);
    @(negedge clk);
    miss_valid = gap;
    miss_addr = addr ^ 32'h0000_0040;
    for (int k = 0; k < 8; k++) begin
      if (gap) begin
        mem_beat_valid = 1'b0;
        #1;
        check(!miss_ready && !mem_req_valid, "R7 stall during fill", {510'b0, miss_ready, mem_req_valid}, 0);
        check(!ld_valid, "R9 gap no release", ld_valid, 0);
        @(negedge clk);
      end
      mem_beat_valid = 1'b1;
      mem_beat_data = chunk_val(seed, (st + k) % 8);
      #1;
      if (k == 0) begin
        check(ld_valid, "R3 release on first beat", ld_valid, 1);
        check(ld_data == chunk_val(seed, st), "R3 requested chunk first", ld_data, chunk_val(seed, st));
      end else begin
        check(!ld_valid, "R4 no release on later beat", ld_valid, 0);
      end
      @(negedge clk);
    end
    mem_beat_valid = 1'b0;
    #1;
    check(line_done, "R6 line_done after last beat", line_done, 1);
    check(arr_wr_addr == exp_base, "R6 array address", arr_wr_addr, exp_base);
    check(arr_wr_data == exp_line, "R5 wrapped placement", arr_wr_data, exp_line);
    check(!miss_ready, "R7 closed on done cycle", miss_ready, 0);
    @(negedge clk);
    miss_valid = 1'b0;
    #1;
    check(!line_done, "R6 single pulse", line_done, 0);
    check(miss_ready, "R7 reopens after done", miss_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(miss_ready && !ld_valid && !line_done && !mem_req_valid, "R1 reset state",
          {508'b0, miss_ready, ld_valid, line_done, mem_req_valid}, 4'b1000);
    rst_n = 1'b1;
    for (int v = 0; v < 10; v++) do_fill(V_ADDR[v], V_SEED[v], V_GAP[v]);

    @(negedge clk);
    mem_beat_valid = 1'b1; mem_beat_data = 64'hBAD0_BAD0_BAD0_BAD0;
    #1;
    check(!ld_valid, "R8 stray beat ignored", ld_valid, 0);
    @(negedge clk);
    #1;
    check(!ld_valid && miss_ready, "R8 still idle", {510'b0, ld_valid, miss_ready}, 1);
    mem_beat_valid = 1'b0;
    do_fill(32'h0000_5038, 32'h9999_000B, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule